// File: doc/BRIEF.md
# Thread Coordinate and Warp Former

This block takes the shape of one three-dimensional thread block, the position of that block in the grid, and the problem extents. It walks every thread of the block in linear order and packs the threads into warps of 32 lanes. For each lane it produces the thread's global (i, j, k) coordinates and two masks. The first mask marks lanes that hold a real thread of the block. The second marks lanes whose thread falls inside the problem extents.

A single `start` pulse launches a block. Warps then leave on a valid/ready stream, one warp per accepted transfer, in increasing warp number. A one-cycle `done` pulse follows the last warp. Block dimensions range from 1 to 16 on each axis, and their product is at most 1024 threads. As an example, a 4x4x4 block holds 64 threads and leaves as exactly two full warps. A 128x128x128 problem tiled with such blocks forms a grid of 32x32x32 blocks.

Top module: `warp_former`

## Requirements
- R1: After reset `out_valid` and `done` are 0. A `start` pulse while idle captures all inputs, and `out_valid` is 1 from the next cycle with `warp_num` 0.
- R2: Lane l of warp w carries linear thread t = 32*w + l. The thread indices are tx = t mod Bx, ty = (t / Bx) mod By and tz = t / (Bx*By), so x varies fastest, then y, then z.
- R3: The global coordinate on each axis is the block dimension times the block index plus the thread index. Lane l's value sits at bits [16*l +: 16] of `coord_i`, `coord_j` and `coord_k`.
- R4: Bit l of `lane_live` is 1 exactly when t < Bx*By*Bz. When the thread count is not a multiple of 32, the unused lanes of the final warp read 0.
- R5: Bit l of `lane_act` is 1 exactly when the lane is live and i < `ext_x`, j < `ext_y` and k < `ext_z`.
- R6: A block emits ceil(Bx*By*Bz / 32) warps, numbered from 0 upward, advancing by one on each accepted transfer. This covers the 1024-thread block, which emits 32 warps.
- R7: While `out_valid` is 1 and `out_ready` is 0, the warp number, the coordinates and the masks hold steady.
- R8: `done` is 1 for exactly the one cycle after the last warp is accepted, and `out_valid` is 0 in that cycle.
- R9: A `start` pulse while a block is in progress is ignored. The remaining warps still follow the first block's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| bdim_x | input | 5 | Block size along x (1..16) |
| bdim_y | input | 5 | Block size along y (1..16) |
| bdim_z | input | 5 | Block size along z (1..16) |
| bidx_x | input | 12 | Block position in the grid along x |
| bidx_y | input | 12 | Block position in the grid along y |
| bidx_z | input | 12 | Block position in the grid along z |
| ext_x | input | 16 | Problem extent along x |
| ext_y | input | 16 | Problem extent along y |
| ext_z | input | 16 | Problem extent along z |
| out_ready | input | 1 | Consumer accepts the current warp |
| out_valid | output | 1 | A warp is presented |
| warp_num | output | 5 | Index of the warp within the block |
| coord_i | output | 512 | Per-lane global x coordinates, 16 bits per lane |
| coord_j | output | 512 | Per-lane global y coordinates, 16 bits per lane |
| coord_k | output | 512 | Per-lane global z coordinates, 16 bits per lane |
| lane_live | output | 32 | Lanes holding a thread of the block |
| lane_act | output | 32 | Live lanes inside the problem extents |
| done | output | 1 | One-cycle pulse after the last warp |

## Verification
The hardest case to reach from the ports is a warp that straddles several rows and planes of an odd-shaped block. In such a warp the x and y wrap points fall at different lanes, and the last warp is only partly filled. The stimulus uses odd dimensions such as 3x5x7, together with random shapes whose product is held to 1024 or less. Extents are drawn just past the block's base, so the in-bounds mask cuts through the middle of a warp. Ready stalls are inserted at random, and a second `start` is pushed during those stalls, so that hold behaviour and the ignored launch are both checked in the middle of a block.

// File: rtl/warp_former.sv
module warp_former #(
  parameter int LANES       = 32,
  parameter int DIM_W       = 5,
  parameter int IDX_W       = 12,
  parameter int COORD_W     = 16,
  parameter int MAX_THREADS = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [DIM_W-1:0]           bdim_x,
  input  logic [DIM_W-1:0]           bdim_y,
  input  logic [DIM_W-1:0]           bdim_z,
  input  logic [IDX_W-1:0]           bidx_x,
  input  logic [IDX_W-1:0]           bidx_y,
  input  logic [IDX_W-1:0]           bidx_z,
  input  logic [COORD_W-1:0]         ext_x,
  input  logic [COORD_W-1:0]         ext_y,
  input  logic [COORD_W-1:0]         ext_z,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [$clog2(MAX_THREADS/LANES)-1:0] warp_num,
  output logic [LANES*COORD_W-1:0]   coord_i,
  output logic [LANES*COORD_W-1:0]   coord_j,
  output logic [LANES*COORD_W-1:0]   coord_k,
  output logic [LANES-1:0]           lane_live,
  output logic [LANES-1:0]           lane_act,
  output logic                       done
);
  localparam int TOT_W = $clog2(MAX_THREADS) + 1;
  localparam int WN_W  = $clog2(MAX_THREADS/LANES);

  logic                busy;
  logic [DIM_W-1:0]    bx, by, bz;
  logic [DIM_W-1:0]    cx, cy, cz;
  logic [COORD_W-1:0]  base_i, base_j, base_k;
  logic [COORD_W-1:0]  ex, ey, ez;
  logic [TOT_W-1:0]    total;
  logic [TOT_W:0]      next_base;
  logic                last;

  logic [DIM_W-1:0] lx [LANES+1];
  logic [DIM_W-1:0] ly [LANES+1];
  logic [DIM_W-1:0] lz [LANES+1];

  assign lx[0] = cx;
  assign ly[0] = cy;
  assign lz[0] = cz;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DIM_W-1:0]   nx, ny;
    logic               wx, wy;
    logic [TOT_W-1:0]   tid;
    logic [COORD_W-1:0] gi, gj, gk;

    assign nx = lx[l] + DIM_W'(1);
    assign ny = ly[l] + DIM_W'(1);
    assign wx = (nx == bx);
    assign wy = (ny == by);
    assign lx[l+1] = wx ? '0 : nx;
    assign ly[l+1] = !wx ? ly[l] : (wy ? '0 : ny);
    assign lz[l+1] = (wx && wy) ? lz[l] + DIM_W'(1) : lz[l];

    assign tid = TOT_W'(warp_num) * TOT_W'(LANES) + TOT_W'(l);
    assign gi  = base_i + COORD_W'(lx[l]);
    assign gj  = base_j + COORD_W'(ly[l]);
    assign gk  = base_k + COORD_W'(lz[l]);

    assign coord_i[l*COORD_W +: COORD_W] = gi;
    assign coord_j[l*COORD_W +: COORD_W] = gj;
    assign coord_k[l*COORD_W +: COORD_W] = gk;
    assign lane_live[l] = (tid < total);
    assign lane_act[l]  = lane_live[l] && (gi < ex) && (gj < ey) && (gk < ez);
  end

  assign out_valid = busy;
  assign next_base = (TOT_W+1)'(warp_num) * (TOT_W+1)'(LANES) + (TOT_W+1)'(LANES);
  assign last      = (next_base >= {1'b0, total});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      warp_num <= '0;
      bx <= '0; by <= '0; bz <= '0;
      cx <= '0; cy <= '0; cz <= '0;
      base_i <= '0; base_j <= '0; base_k <= '0;
      ex <= '0; ey <= '0; ez <= '0;
      total <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy     <= 1'b1;
        warp_num <= '0;
        bx <= bdim_x; by <= bdim_y; bz <= bdim_z;
        cx <= '0; cy <= '0; cz <= '0;
        base_i <= COORD_W'(bdim_x) * COORD_W'(bidx_x);
        base_j <= COORD_W'(bdim_y) * COORD_W'(bidx_y);
        base_k <= COORD_W'(bdim_z) * COORD_W'(bidx_z);
        ex <= ext_x; ey <= ext_y; ez <= ext_z;
        total <= TOT_W'(bdim_x) * TOT_W'(bdim_y) * TOT_W'(bdim_z);
      end else if (busy && out_ready) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          warp_num <= warp_num + WN_W'(1);
          cx <= lx[LANES];
          cy <= ly[LANES];
          cz <= lz[LANES];
        end
      end
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(warp_num) && $stable(coord_i)
                                   && $stable(coord_j) && $stable(coord_k) && $stable(lane_live)))
    else $error("R7 warp changed while stalled");

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid)
    else $error("R8 done while a warp is presented");

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("R8 done longer than one cycle");

  a_r4_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lane_live[0])
    else $error("R4 presented warp with empty lane 0");

  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((lane_live & (lane_live + LANES'(1))) == '0))
    else $error("R4 live mask not a low-order run");

  a_r5_act_subset: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((lane_act & ~lane_live) == '0))
    else $error("R5 active lane without a thread");

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid && out_ready)) |-> (warp_num == $past(warp_num) + WN_W'(1)))
    else $error("R6 warp number did not advance by one");

endmodule

// File: tb/warp_former_test.sv
module warp_former_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0]  bdim_x = '0, bdim_y = '0, bdim_z = '0;
  logic [11:0] bidx_x = '0, bidx_y = '0, bidx_z = '0;
  logic [15:0] ext_x = '0, ext_y = '0, ext_z = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [4:0] warp_num;
  logic [511:0] coord_i, coord_j, coord_k;
  logic [31:0] lane_live, lane_act;
  logic done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  warp_former uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bdim_x(bdim_x), .bdim_y(bdim_y), .bdim_z(bdim_z),
    .bidx_x(bidx_x), .bidx_y(bidx_y), .bidx_z(bidx_z),
    .ext_x(ext_x), .ext_y(ext_y), .ext_z(ext_z),
    .out_ready(out_ready), .out_valid(out_valid), .warp_num(warp_num),
    .coord_i(coord_i), .coord_j(coord_j), .coord_k(coord_k),
    .lane_live(lane_live), .lane_act(lane_act), .done(done)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_block(int bx, int by, int bz, int ix, int iy, int iz,
                           int ex, int ey, int ez, bit stall, bit poke);
    int total, nw, w;
    logic [4:0] held_w;
    logic [511:0] held_i;
    @(negedge clk);
    bdim_x = 5'(bx); bdim_y = 5'(by); bdim_z = 5'(bz);
    bidx_x = 12'(ix); bidx_y = 12'(iy); bidx_z = 12'(iz);
    ext_x = 16'(ex); ext_y = 16'(ey); ext_z = 16'(ez);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    total = bx * by * bz;
    nw = (total + 31) / 32;
    w = 0;
    while (w < nw) begin
      if (stall && ($urandom % 3 == 0)) begin
        out_ready = 1'b0;
        held_w = warp_num;
        held_i = coord_i;
        if (poke) begin
          bdim_x = 5'd16; bdim_y = 5'd2; bidx_x = 12'd7; ext_x = 16'd1;
          start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R7", "held warp_num", warp_num, held_w);
        chk(poke ? "R9" : "R7", "held coord_i", (coord_i == held_i) ? 1 : 0, 1);
        continue;
      end
      begin
        logic [31:0] e_live, e_act;
        int bad;
        bad = 0;
        e_live = '0; e_act = '0;
        chk("R1", "out_valid", out_valid, 1);
        chk("R6", "warp_num", warp_num, w);
        for (int l = 0; l < 32; l++) begin
          int t, tx, ty, tz, gi, gj, gk;
          t  = w * 32 + l;
          tx = t % bx;
          ty = (t / bx) % by;
          tz = t / (bx * by);
          gi = bx * ix + tx;
          gj = by * iy + ty;
          gk = bz * iz + tz;
          if (t < total) begin
            e_live[l] = 1'b1;
            e_act[l] = (gi < ex) && (gj < ey) && (gk < ez);
            if (int'(coord_i[l*16 +: 16]) != gi || int'(coord_j[l*16 +: 16]) != gj ||
                int'(coord_k[l*16 +: 16]) != gk) begin
              if (bad == 0)
                $display("FAIL R2/R3 lane %0d actual=(%0d,%0d,%0d) expected=(%0d,%0d,%0d)", l,
                         coord_i[l*16 +: 16], coord_j[l*16 +: 16], coord_k[l*16 +: 16], gi, gj, gk);
              bad++;
            end
          end
        end
        checks++;
        if (bad != 0) errors++;
        chk("R4", "lane_live", lane_live, e_live);
        chk("R5", "lane_act", lane_act, e_act);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        w++;
      end
    end
    chk("R8", "done after last warp", done, 1);
    chk("R8", "out_valid with done", out_valid, 0);
    @(negedge clk);
    chk("R8", "done pulse width", done, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", out_valid, 0);
    chk("R1", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle out_valid", out_valid, 0);

    run_block(4, 4, 4, 31, 31, 31, 128, 128, 128, 0, 0);
    run_block(4, 4, 4, 31, 31, 31, 126, 128, 127, 0, 0);
    run_block(1, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0);
    run_block(16, 16, 4, 0, 0, 0, 16, 16, 4, 0, 0);
    run_block(3, 5, 7, 2, 1, 0, 8, 9, 7, 1, 1);
    run_block(7, 1, 1, 0, 0, 0, 100, 1, 1, 1, 0);

    for (int n = 0; n < 25; n++) begin
      int bx, by, bz, ix, iy, iz;
      do begin
        bx = 1 + $urandom % 16;
        by = 1 + $urandom % 16;
        bz = 1 + $urandom % 16;
      end while (bx * by * bz > 1024);
      ix = $urandom % 2048;
      iy = $urandom % 2048;
      iz = $urandom % 2048;
      run_block(bx, by, bz, ix, iy, iz,
                bx * ix + $urandom % (bx + 2),
                by * iy + $urandom % (by + 2),
                bz * iz + $urandom % (bz + 2),
                1, (n % 4 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule